// File: doc/BRIEF.md
# Watchdog Timer with Programmable Reset Pulse

This block is a watchdog peripheral that sits on a simple 32-bit register bus with word access. Software loads a reload value and enables counting. A down-counter then steps on every clock, or on a 1 MHz tick derived from the clock by a prescaler. To keep the counter from running out, software writes a 16-bit restart code, which copies the reload value back into the counter.

When the counter runs out, the block raises a one-cycle expiry strobe. Depending on the control bits, it can also latch an interrupt and drive a reset pulse. The pulse width is given in ticks. Its polarity and drive style can only be changed by special codes in the top byte of the pulse register. An input that signals an SDRAM-controller reset turns an expiry into a silent shutdown: control is zeroed and nothing is asserted.

Top module: `wdog_top`

## Requirements
- R1: After reset, the count (word 0x00) and the reload value (word 0x04) both read 0x014FB180. Control (word 0x0C) reads 0 and the pulse register (word 0x18) reads 0x000000FF. `irq` and `expire_evt` are low. `rst_pulse` rests high (active-low by default) and `rst_pulse_oe` is low.
- R2: A write to byte offset 0x08 whose low 16 bits are 0x4755 copies the reload value into the count and clears `irq`. Any other value written there changes nothing.
- R3: Reads decode as follows: 0x00 gives the count, 0x04 the reload value, 0x0C control, 0x18 the pulse register, and 0x1C plain 32-bit storage. Offset 0x08 and all unmapped offsets read 0 and ignore writes. Writes to 0x00 are ignored. An address whose two low bits are not zero does not decode.
- R4: A control write is stored with bits 9:7 forced to 0.
- R5: The enable bit is control bit 0. A control write that raises it loads the count from the reload value. A write that lowers it freezes the count. A write that leaves it unchanged does not touch the count.
- R6: Control bit 4 = 0 steps the count on every clock. Control bit 4 = 1 steps it once per 1 µs tick, that is once every CLK_HZ/1 MHz clocks.
- R7: The count runs out on the step that takes it from 1 (or from 0) to 0. That step pulses `expire_evt` for one cycle and stops counting. If control bit 2 is set, `irq` rises in the same cycle and stays high until a valid restart.
- R8: When the count runs out and control bit 1 or bit 3 is set, a reset pulse starts on the next clock. It lasts pulse-register bits 19:0 ticks of the selected tick. Bit 31 = 1 makes `rst_pulse` active-high; bit 31 = 0 makes it active-low. Bit 30 = 1 holds `rst_pulse_oe` high at all times; bit 30 = 0 raises it only while the pulse is active.
- R9: A pulse-register write always replaces bits 19:0. Its top byte acts as a code: 0xA5 sets bit 31, 0x5A clears bit 31, 0xA8 sets bit 30, 0x8A clears bit 30. Any other top byte keeps bits 31:30.
- R10: If `sdram_rst_busy` is high when the count runs out, there is no `expire_evt`, no `irq` and no pulse, and control becomes 0.
- R11: A valid restart in the same cycle as the final step wins. The count reloads and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| sdram_rst_busy | input | 1 | SDRAM-controller reset in progress |
| expire_evt | output | 1 | One-cycle expiry strobe |
| irq | output | 1 | Latched watchdog interrupt |
| rst_pulse | output | 1 | Reset pulse, programmable polarity |
| rst_pulse_oe | output | 1 | Drive enable for the reset pulse |

## Verification
The restart write and the final count step can land on the same clock edge. The bench enables a reload of 4 and issues the restart on exactly the fourth edge after enable. It then checks three things: the count reads 4 again, the expiry strobe counter has not moved, and `irq` is still low. It also checks that the interrupt arrives exactly four edges later, which shows that the restart truly reloaded the count and did not merely mask one event.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int unsigned DW = 32;

    // Word indices (byte offset / 4)
    localparam int unsigned IDX_COUNT  = 0;
    localparam int unsigned IDX_RELOAD = 1;
    localparam int unsigned IDX_KICK   = 2;
    localparam int unsigned IDX_CTRL   = 3;
    localparam int unsigned IDX_PULSE  = 6;
    localparam int unsigned IDX_SCRATCH = 7;

    localparam logic [15:0] KICK_CODE = 16'h4755;

    // Top-byte codes of the pulse register
    localparam logic [7:0] CODE_POL_HIGH = 8'hA5;
    localparam logic [7:0] CODE_POL_LOW  = 8'h5A;
    localparam logic [7:0] CODE_PP_ON    = 8'hA8;
    localparam logic [7:0] CODE_PP_OFF   = 8'h8A;

    // Control bits
    localparam int unsigned CB_EN    = 0;
    localparam int unsigned CB_RST   = 1;
    localparam int unsigned CB_IRQ   = 2;
    localparam int unsigned CB_EXT   = 3;
    localparam int unsigned CB_SLOW  = 4;
    localparam logic [DW-1:0] CTRL_DROP = 32'h0000_0380;

    typedef struct packed {
        logic [DW-1:0] count;
        logic [DW-1:0] reload;
        logic [DW-1:0] ctrl;
        logic [DW-1:0] pulse;
        logic [DW-1:0] scratch;
        logic          run;
        logic          expire;
        logic          irq;
        logic          go;
    } wd_state_t;
endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
    parameter int unsigned CLK_HZ  = 24_000_000,
    parameter int unsigned TICK_HZ = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned DIV = (CLK_HZ / TICK_HZ == 0) ? 1 : CLK_HZ / TICK_HZ;
    localparam int unsigned CW  = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                if (cnt_q == CW'(DIV - 1)) cnt_d = '0;
                else                        cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick = (cnt_q == CW'(DIV - 1));

            // R6: the slow tick is never two cycles wide
            assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int unsigned WB = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          tick,
    input  logic [WB-1:0] width,
    input  logic          pol_high,
    input  logic          push_pull,
    output logic          rst_out,
    output logic          rst_oe
);
    logic [WB-1:0] cnt_d, cnt_q;
    logic          active;

    always_comb begin
        cnt_d = cnt_q;
        if (start)                    cnt_d = width;
        else if (tick && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active  = (cnt_q != '0);
    assign rst_out = pol_high ? active : !active;
    assign rst_oe  = push_pull | active;

    // R8: a start with nonzero width makes the pulse active on the next cycle
    assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && width != '0) |=> active);
    // R8: without a tick the pulse cannot end
    assert_pulse_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start && !tick) |=> active);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int unsigned AW          = 8,
    parameter int unsigned WB          = 20,
    parameter logic [31:0] RESET_COUNT = 32'h014F_B180
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          tick_us,
    input  logic          sdram_busy,
    output logic          expire_evt,
    output logic          irq,
    output logic          pulse_go,
    output logic [WB-1:0] pulse_width,
    output logic          pulse_tick,
    output logic          pol_high,
    output logic          push_pull
);
    localparam int unsigned IW = AW - 2;
    localparam logic [DW-1:0] PULSE_RESET = 32'h0000_00FF;

    wd_state_t s_d, s_q;

    logic          aligned, wr, kick, ctrl_wr, en_rise, en_fall, step, fire;
    logic [IW-1:0] widx;
    logic [DW-1:0] new_ctrl;
    logic [DW-1:0] new_pulse;

    always_comb begin
        aligned  = (bus_addr[1:0] == 2'b00);
        widx     = bus_addr[AW-1:2];
        wr       = bus_sel && bus_wr && aligned;
        kick     = wr && widx == IW'(IDX_KICK) && bus_wdata[15:0] == KICK_CODE;
        ctrl_wr  = wr && widx == IW'(IDX_CTRL);
        new_ctrl = bus_wdata & ~CTRL_DROP;
        en_rise  = ctrl_wr && new_ctrl[CB_EN] && !s_q.ctrl[CB_EN];
        en_fall  = ctrl_wr && !new_ctrl[CB_EN] && s_q.ctrl[CB_EN];
        pulse_tick = s_q.ctrl[CB_SLOW] ? tick_us : 1'b1;
        step     = s_q.ctrl[CB_EN] && s_q.run && pulse_tick;
        fire     = step && (s_q.count <= 32'd1) && !kick && !en_rise && !en_fall;

        new_pulse = s_q.pulse;
        unique case (bus_wdata[31:24])
            CODE_POL_HIGH: new_pulse[31] = 1'b1;
            CODE_POL_LOW:  new_pulse[31] = 1'b0;
            CODE_PP_ON:    new_pulse[30] = 1'b1;
            CODE_PP_OFF:   new_pulse[30] = 1'b0;
            default:       ;
        endcase
        new_pulse[WB-1:0] = bus_wdata[WB-1:0];

        s_d        = s_q;
        s_d.expire = 1'b0;
        s_d.go     = 1'b0;

        if (wr && widx == IW'(IDX_RELOAD))  s_d.reload  = bus_wdata;
        if (wr && widx == IW'(IDX_SCRATCH)) s_d.scratch = bus_wdata;
        if (wr && widx == IW'(IDX_PULSE))   s_d.pulse   = new_pulse;
        if (ctrl_wr)                        s_d.ctrl    = new_ctrl;

        if (kick) begin
            s_d.count = s_q.reload;
            s_d.run   = s_q.ctrl[CB_EN];
            s_d.irq   = 1'b0;
        end else if (en_rise) begin
            s_d.count = s_q.reload;
            s_d.run   = 1'b1;
        end else if (en_fall) begin
            s_d.run = 1'b0;
        end else if (fire) begin
            s_d.count = '0;
            s_d.run   = 1'b0;
            if (sdram_busy) begin
                s_d.ctrl = '0;
            end else begin
                s_d.expire = 1'b1;
                s_d.irq    = s_q.irq | s_q.ctrl[CB_IRQ];
                s_d.go     = s_q.ctrl[CB_RST] | s_q.ctrl[CB_EXT];
            end
        end else if (step) begin
            s_d.count = s_q.count - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.count   <= RESET_COUNT;
            s_q.reload  <= RESET_COUNT;
            s_q.pulse   <= PULSE_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (widx)
                IW'(IDX_COUNT):   bus_rdata = s_q.count;
                IW'(IDX_RELOAD):  bus_rdata = s_q.reload;
                IW'(IDX_CTRL):    bus_rdata = s_q.ctrl;
                IW'(IDX_PULSE):   bus_rdata = s_q.pulse;
                IW'(IDX_SCRATCH): bus_rdata = s_q.scratch;
                default:          bus_rdata = '0;
            endcase
        end
    end

    assign expire_evt  = s_q.expire;
    assign irq         = s_q.irq;
    assign pulse_go    = s_q.go;
    assign pulse_width = s_q.pulse[WB-1:0];
    assign pol_high    = s_q.pulse[31];
    assign push_pull   = s_q.pulse[30];

    assert_kick_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (s_q.count == $past(s_q.reload)) && !s_q.irq);
    assert_ctrl_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (s_q.ctrl[9:7] == 3'b000));
    assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.irq && !kick) |=> s_q.irq);
    assert_sdram_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && sdram_busy) |=> (!s_q.expire && !s_q.go && s_q.ctrl == '0));
    assert_kick_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !s_q.expire);
endmodule

// File: rtl/wdog_top.sv
module wdog_top #(
    parameter int unsigned CLK_HZ      = 24_000_000,
    parameter int unsigned TICK_HZ     = 1_000_000,
    parameter int unsigned AW          = 8,
    parameter int unsigned WB          = 20,
    parameter logic [31:0] RESET_COUNT = 32'h014F_B180
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic          sdram_rst_busy,
    output logic          expire_evt,
    output logic          irq,
    output logic          rst_pulse,
    output logic          rst_pulse_oe
);
    logic          tick_us, pulse_go, pulse_tick, pol_high, push_pull;
    logic [WB-1:0] pulse_width;

    wdog_tick #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick_us)
    );

    wdog_core #(.AW(AW), .WB(WB), .RESET_COUNT(RESET_COUNT)) u_core (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_us(tick_us), .sdram_busy(sdram_rst_busy),
        .expire_evt(expire_evt), .irq(irq),
        .pulse_go(pulse_go), .pulse_width(pulse_width), .pulse_tick(pulse_tick),
        .pol_high(pol_high), .push_pull(push_pull)
    );

    wdog_pulse #(.WB(WB)) u_pulse (
        .clk(clk), .rst_n(rst_n),
        .start(pulse_go), .tick(pulse_tick), .width(pulse_width),
        .pol_high(pol_high), .push_pull(push_pull),
        .rst_out(rst_pulse), .rst_oe(rst_pulse_oe)
    );
endmodule

// File: tb/wdog_top_test.sv
module wdog_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sdram_rst_busy = 1'b0;
    logic        expire_evt, irq, rst_pulse, rst_pulse_oe;

    int total = 0, fails = 0, exp_seen = 0;

    wdog_top uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sdram_rst_busy(sdram_rst_busy), .expire_evt(expire_evt), .irq(irq),
        .rst_pulse(rst_pulse), .rst_pulse_oe(rst_pulse_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (rst_n && expire_evt) exp_seen++;

    // {write addr, write data, read addr, expected read, requirement}
    localparam logic [87:0] VEC [NVEC] = '{
        {8'h04, 32'h0000_0100, 8'h04, 32'h0000_0100, 8'd3},  // R3 reload storage
        {8'h08, 32'h0000_1234, 8'h00, 32'h014F_B180, 8'd2},  // R2 bad code ignored
        {8'h08, 32'hABCD_4755, 8'h00, 32'h0000_0100, 8'd2},  // R2 restart reloads
        {8'h00, 32'h0000_DEAD, 8'h00, 32'h0000_0100, 8'd3},  // R3 count read-only
        {8'h0C, 32'h0000_03FE, 8'h0C, 32'h0000_007E, 8'd4},  // R4 bits 9:7 dropped
        {8'h0C, 32'h0000_0000, 8'h0C, 32'h0000_0000, 8'd4},
        {8'h1C, 32'h0000_CAFE, 8'h1C, 32'h0000_CAFE, 8'd3},  // R3 scratch
        {8'h05, 32'h0000_0777, 8'h04, 32'h0000_0100, 8'd3},  // R3 misaligned ignored
        {8'h30, 32'h0000_0055, 8'h30, 32'h0000_0000, 8'd3},  // R3 unmapped
        {8'h18, 32'hA500_0010, 8'h18, 32'h8000_0010, 8'd9},  // R9 polarity high
        {8'h18, 32'hA800_0020, 8'h18, 32'hC000_0020, 8'd9},  // R9 push-pull on
        {8'h18, 32'h1200_0030, 8'h18, 32'hC000_0030, 8'd9},  // R9 no code
        {8'h18, 32'h5A00_0040, 8'h18, 32'h4000_0040, 8'd9},  // R9 polarity low
        {8'h18, 32'h8A0F_FFFF, 8'h18, 32'h000F_FFFF, 8'd9}   // R9 open drain
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v, v1, v2;
        int k, hi, oe_hi, snap;

        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        bus_read(8'h00, v); check("R1 count", v, 32'h014F_B180);
        bus_read(8'h04, v); check("R1 reload", v, 32'h014F_B180);
        bus_read(8'h0C, v); check("R1 ctrl", v, 32'h0);
        bus_read(8'h18, v); check("R1 pulse reg", v, 32'h0000_00FF);
        check("R1 outputs", {28'd0, irq, expire_evt, rst_pulse, rst_pulse_oe}, 32'h2);

        for (int i = 0; i < NVEC; i++) begin
            logic [87:0] e;
            e = VEC[i];
            bus_write(e[87:80], e[79:48]);
            bus_read(e[47:40], v);
            total++;
            if (v !== e[39:8]) begin
                fails++;
                $display("FAIL R%0d vector %0d: actual 0x%08h expected 0x%08h",
                         e[7:0], i, v, e[39:8]);
            end
        end

        // R6/R7/R8: per-clock count, expiry, active-high pulse of 3
        bus_write(8'h04, 32'd10);
        bus_write(8'h18, 32'hA500_0003);
        bus_write(8'h0C, 32'h7);
        k = 0;
        while (!expire_evt && k < 50) begin @(negedge clk); k++; end
        check("R6 clocks to expiry", k, 10);
        check("R7 irq on expiry", irq, 1'b1);
        hi = 0; oe_hi = 0;
        repeat (8) begin @(negedge clk); if (rst_pulse) hi++; if (rst_pulse_oe) oe_hi++; end
        check("R8 pulse width", hi, 3);
        check("R8 open-drain enable", oe_hi, 3);
        step(20);
        bus_read(8'h00, v); check("R7 stopped at zero", v, 0);
        check("R7 single event", exp_seen, 1);
        check("R7 irq held", irq, 1'b1);
        bus_write(8'h0C, 32'h0);
        bus_write(8'h08, 32'h0000_4755);
        check("R2 restart clears irq", irq, 1'b0);

        // R6: slow tick, no irq when bit 2 clear
        bus_write(8'h04, 32'd3);
        bus_write(8'h0C, 32'h11);
        k = 0;
        while (!expire_evt && k < 100) begin @(negedge clk); k++; end
        check("R6 slow tick window", (k >= 49 && k <= 72), 1'b1);
        check("R7 no irq without bit 2", irq, 1'b0);
        step(2);
        check("R8 no pulse without bits 1/3", rst_pulse, 1'b0);
        bus_write(8'h0C, 32'h0);

        // R5 enable edges
        bus_write(8'h04, 32'd200);
        bus_write(8'h0C, 32'h1);
        bus_read(8'h00, v); check("R5 enable reloads", v, 32'd200);
        step(5);
        bus_write(8'h0C, 32'h1);
        bus_read(8'h00, v1);
        check("R5 unchanged enable no reload", (v1 < 32'd195 && v1 > 32'd180), 1'b1);
        bus_write(8'h0C, 32'h0);
        bus_read(8'h00, v1);
        step(10);
        bus_read(8'h00, v2); check("R5 disable freezes", v2, v1);

        // R10 SDRAM reset suppresses expiry
        snap = exp_seen;
        sdram_rst_busy = 1'b1;
        bus_write(8'h04, 32'd5);
        bus_write(8'h0C, 32'hF);
        step(15);
        check("R10 no expiry", exp_seen, snap);
        check("R10 no irq", irq, 1'b0);
        check("R10 pulse idle", rst_pulse, 1'b0);
        bus_read(8'h0C, v); check("R10 ctrl cleared", v, 0);
        bus_read(8'h00, v); check("R10 count at zero", v, 0);
        sdram_rst_busy = 1'b0;

        // R11 restart on the expiry edge
        snap = exp_seen;
        bus_write(8'h04, 32'd4);
        bus_write(8'h0C, 32'h5);
        step(3);
        bus_write(8'h08, 32'h0000_4755);
        bus_read(8'h00, v); check("R11 count reloaded", v, 32'd4);
        check("R11 no expiry", exp_seen, snap);
        check("R11 irq low", irq, 1'b0);
        step(3);
        check("R11 irq not early", irq, 1'b0);
        step(1);
        check("R11 irq after full reload", irq, 1'b1);
        bus_write(8'h0C, 32'h0);
        bus_write(8'h08, 32'h0000_4755);

        // R8/R9 active-low, push-pull, external-pulse bit only
        bus_write(8'h18, 32'h5A00_0002);
        bus_write(8'h18, 32'hA800_0002);
        bus_read(8'h18, v); check("R9 code sequence", v, 32'h4000_0002);
        check("R8 idle high", rst_pulse, 1'b1);
        check("R8 push-pull always driven", rst_pulse_oe, 1'b1);
        bus_write(8'h04, 32'd2);
        bus_write(8'h0C, 32'h9);
        hi = 0; oe_hi = 0;
        repeat (12) begin @(negedge clk); if (!rst_pulse) hi++; if (rst_pulse_oe) oe_hi++; end
        check("R8 active-low width", hi, 2);
        check("R8 oe constant", oe_hi, 12);
        check("R7 no irq for ext only", irq, 1'b0);

        summary();
        $finish;
    end
endmodule